// File: doc/BRIEF.md
# Per-ID Read Ordering Scoreboard

This block watches the read-address and read-data channels of a memory-mapped bus and checks that read responses return in a legal order. Each accepted read request is given a sequence number. The request is then queued, with its beat count, in a small FIFO that belongs to its ID. The FIFO depth is a parameter. So is the ID width, because an interconnect that merges masters adds bits to the ID field.

The data channel is only observed. Every handshaken beat is charged to the oldest outstanding request of its ID. When the final beat of a burst arrives, that request is retired, and one cycle later the block reports the ID, the sequence number and a verdict. Responses for different IDs may overtake one another freely. A burst whose beat count fits a younger request of the same ID is reported as an ordering fault. Any other count mismatch is reported as a length fault. A beat whose ID has nothing outstanding is reported as an unexpected response.

The block also drives the address channel's ready. Ready falls for an ID whose queue is full, so no request is lost from the record.

Top module: `rd_order_chk`

## Requirements
- R1: `ar_ready` is low exactly when the queue of the ID on `ar_id` already holds DEPTH outstanding requests. Requests for other IDs are still accepted. A retirement in the same cycle does not raise `ar_ready`.
- R2: Accepted requests get sequence numbers 0, 1, 2, … in acceptance order from reset, counted across all IDs and wrapping at 2^SEQ_W.
- R3: A handshaken beat with `r_last` = 1 on an ID that has outstanding requests retires that ID's oldest request. In the next cycle `done_valid` is 1 for one cycle, with `done_id` and `done_seq` of the retired request.
- R4: A handshaken beat on an ID with no outstanding request raises `err_unknown` for one cycle in the next cycle. It does not raise `done_valid` and does not change any queue.
- R5: Bursts of different IDs may complete in any relative order without any error flag.
- R6: A burst whose beat count equals `ar_len`+1 of the retired request completes with `err_order` and `err_length` both 0.
- R7: If the beat count differs from the retired request's `ar_len`+1 but equals `ar_len`+1 of a younger outstanding request of the same ID, `err_order` is 1 together with `done_valid`.
- R8: If the beat count matches neither the retired request nor any younger request of that ID, `err_length` is 1 together with `done_valid`.
- R9: A beat with `r_valid` = 1 and `r_ready` = 0 is ignored. It raises no flag and is not counted.
- R10: After reset, all queues are empty, `ar_ready` is 1 and all report outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read request valid |
| ar_id | input | ID_W | Read request ID |
| ar_len | input | LEN_W | Read request beats minus one |
| ar_ready | output | 1 | Request accepted when high with ar_valid |
| r_valid | input | 1 | Read beat valid |
| r_ready | input | 1 | Read beat ready (observed) |
| r_id | input | ID_W | Read beat ID |
| r_last | input | 1 | Final beat of a burst |
| done_valid | output | 1 | A request was retired last cycle |
| done_id | output | ID_W | ID of the retired request |
| done_seq | output | SEQ_W | Sequence number of the retired request |
| err_order | output | 1 | Retired burst fits a younger same-ID request |
| err_length | output | 1 | Retired burst has a wrong beat count |
| err_unknown | output | 1 | Beat arrived for an ID with nothing outstanding |

## Verification
The assertions assume that at most one data beat is handshaken per cycle. They assume that `r_id` and `r_last` describe that beat, and that reset is held for at least one edge before traffic starts. They do not assume that the source holds its payload stable while waiting, so they stay valid when the stimulus drops `ar_valid` on the cycle after a request is offered. The stimulus offers a request only to an ID whose queue has room, and it probes a full queue with `ar_valid` low. Each beat is driven for exactly one clock edge.

// File: rtl/rdord_pkg.sv
package rdord_pkg;

  typedef enum logic [1:0] {
    VERD_OK     = 2'd0,
    VERD_ORDER  = 2'd1,
    VERD_LENGTH = 2'd2
  } verdict_e;

  // slot reached k steps after ptr in a ring of the given depth
  function automatic int unsigned ring_slot(int unsigned ptr, int unsigned k,
                                            int unsigned depth);
    return (ptr + k) % depth;
  endfunction

  // beats carried by a request whose length field is axlen
  function automatic int unsigned beats_of(int unsigned axlen);
    return axlen + 1;
  endfunction

endpackage

// File: rtl/rdord_idq.sv
module rdord_idq #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [CNT_W-1:0] push_beats,
  input  logic             pop,
  input  logic [CNT_W-1:0] probe_beats,
  output logic             empty,
  output logic             full,
  output logic [SEQ_W-1:0] head_seq,
  output logic [CNT_W-1:0] head_beats,
  output logic             younger_hit
);
  import rdord_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0] seq_mem  [DEPTH];
  logic [CNT_W-1:0] beat_mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [OCC_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return PTR_W'(ring_slot(int'(p), 1, DEPTH));
  endfunction

  assign empty      = (occ_q == '0);
  assign full       = (occ_q == OCC_W'(DEPTH));
  assign head_seq   = seq_mem[rd_q];
  assign head_beats = beat_mem[rd_q];

  always_comb begin
    younger_hit = 1'b0;
    for (int k = 1; k < DEPTH; k++) begin
      if (k < int'(occ_q) &&
          beat_mem[PTR_W'(ring_slot(int'(rd_q), k, DEPTH))] == probe_beats)
        younger_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seq_mem[i]  <= '0;
        beat_mem[i] <= '0;
      end
    end else begin
      if (push) begin
        seq_mem[wr_q]  <= push_seq;
        beat_mem[wr_q] <= push_beats;
        wr_q           <= step(wr_q);
      end
      if (pop) rd_q <= step(rd_q);
      if (push && !pop)      occ_q <= occ_q + OCC_W'(1);
      else if (pop && !push) occ_q <= occ_q - OCC_W'(1);
    end
  end

endmodule

// File: rtl/rdord_judge.sv
module rdord_judge #(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0]  seen_beats,
  input  logic [CNT_W-1:0]  head_beats,
  input  logic              younger_hit,
  output rdord_pkg::verdict_e verdict
);
  import rdord_pkg::*;

  always_comb begin
    if (seen_beats == head_beats) verdict = VERD_OK;
    else if (younger_hit)         verdict = VERD_ORDER;
    else                          verdict = VERD_LENGTH;
  end

endmodule

// File: rtl/rd_order_chk.sv
module rd_order_chk #(
  parameter int ID_W  = 3,
  parameter int DEPTH = 4,
  parameter int LEN_W = 8,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  input  logic [ID_W-1:0]  ar_id,
  input  logic [LEN_W-1:0] ar_len,
  output logic             ar_ready,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic [ID_W-1:0]  r_id,
  input  logic             r_last,
  output logic             done_valid,
  output logic [ID_W-1:0]  done_id,
  output logic [SEQ_W-1:0] done_seq,
  output logic             err_order,
  output logic             err_length,
  output logic             err_unknown
);
  import rdord_pkg::*;

  localparam int NUM_IDS = 1 << ID_W;
  localparam int CNT_W   = LEN_W + 1;

  // named internal events
  logic               ar_take;
  logic               r_take;
  logic               r_known;
  logic               r_retire;
  logic [NUM_IDS-1:0] empty_vec;
  logic [NUM_IDS-1:0] full_vec;
  logic [NUM_IDS-1:0] younger_vec;
  logic [SEQ_W-1:0]   head_seq_arr   [NUM_IDS];
  logic [CNT_W-1:0]   head_beats_arr [NUM_IDS];
  logic [CNT_W-1:0]   seen_q         [NUM_IDS];
  logic [CNT_W-1:0]   beats_now;
  logic [CNT_W-1:0]   req_beats;
  logic [SEQ_W-1:0]   seq_q;
  verdict_e           verdict;

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + CNT_W'(1);
  endfunction

  assign ar_ready  = !full_vec[ar_id];
  assign ar_take   = ar_valid && ar_ready;
  assign req_beats = CNT_W'(beats_of(int'(ar_len)));
  assign r_take    = r_valid && r_ready;
  assign r_known   = !empty_vec[r_id];
  assign r_retire  = r_take && r_last && r_known;
  assign beats_now = sat_inc(seen_q[r_id]);

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_idq
    rdord_idq #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (ar_take && (ar_id == ID_W'(g))),
      .push_seq   (seq_q),
      .push_beats (req_beats),
      .pop        (r_retire && (r_id == ID_W'(g))),
      .probe_beats(beats_now),
      .empty      (empty_vec[g]),
      .full       (full_vec[g]),
      .head_seq   (head_seq_arr[g]),
      .head_beats (head_beats_arr[g]),
      .younger_hit(younger_vec[g])
    );
  end

  rdord_judge #(.CNT_W(CNT_W)) u_judge (
    .seen_beats (beats_now),
    .head_beats (head_beats_arr[r_id]),
    .younger_hit(younger_vec[r_id]),
    .verdict    (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= '0;
      for (int i = 0; i < NUM_IDS; i++) seen_q[i] <= '0;
    end else begin
      if (ar_take) seq_q <= seq_q + SEQ_W'(1);
      if (r_take && r_known) seen_q[r_id] <= r_last ? '0 : beats_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid  <= 1'b0;
      done_id     <= '0;
      done_seq    <= '0;
      err_order   <= 1'b0;
      err_length  <= 1'b0;
      err_unknown <= 1'b0;
    end else begin
      done_valid  <= r_retire;
      done_id     <= r_retire ? r_id : '0;
      done_seq    <= r_retire ? head_seq_arr[r_id] : '0;
      err_order   <= r_retire && (verdict == VERD_ORDER);
      err_length  <= r_retire && (verdict == VERD_LENGTH);
      err_unknown <= r_take && !r_known;
    end
  end

endmodule

// File: rtl/rd_order_chk_sva.sv
module rd_order_chk_sva #(
  parameter int ID_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ar_valid,
  input logic                 ar_ready,
  input logic [ID_W-1:0]      ar_id,
  input logic                 r_valid,
  input logic                 r_ready,
  input logic                 r_last,
  input logic                 done_valid,
  input logic                 err_order,
  input logic                 err_length,
  input logic                 err_unknown,
  input logic [(1<<ID_W)-1:0] empty_vec
);

  // R1: an accepted request is recorded in its ID's queue
  a_r1_push_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> !empty_vec[$past(ar_id)]);

  // R3: a retirement report always follows a handshaken final beat
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(r_valid && r_ready && r_last));

  // R4: an unexpected beat never also reports a retirement
  a_r4_unknown_alone: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown |-> !done_valid);

  // R7 R8: at most one fault kind per cycle
  a_r8_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_order, err_length, err_unknown}));

  // R7: ordering and length faults ride on a retirement
  a_r7_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (err_order || err_length) |-> done_valid);

  // R9: a beat without ready has no effect on the reports
  a_r9_no_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (!done_valid && !err_unknown));

endmodule

bind rd_order_chk rd_order_chk_sva #(.ID_W(ID_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .ar_valid   (ar_valid),
  .ar_ready   (ar_ready),
  .ar_id      (ar_id),
  .r_valid    (r_valid),
  .r_ready    (r_ready),
  .r_last     (r_last),
  .done_valid (done_valid),
  .err_order  (err_order),
  .err_length (err_length),
  .err_unknown(err_unknown),
  .empty_vec  (empty_vec)
);

// File: tb/rd_order_chk_bench.sv
module rd_order_chk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W  = 3;
  localparam int DEPTH = 4;
  localparam int LEN_W = 8;
  localparam int SEQ_W = 8;
  localparam int NIDS  = 1 << ID_W;

  // expected kinds
  localparam int K_OK = 0, K_ORD = 1, K_LEN = 2, K_UNK = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ar_valid = 1'b0;
  logic [ID_W-1:0] ar_id = '0;
  logic [LEN_W-1:0] ar_len = '0;
  logic ar_ready;
  logic r_valid = 1'b0;
  logic r_ready = 1'b1;
  logic [ID_W-1:0] r_id = '0;
  logic r_last = 1'b0;
  logic done_valid;
  logic [ID_W-1:0] done_id;
  logic [SEQ_W-1:0] done_seq;
  logic err_order, err_length, err_unknown;

  int checks = 0;
  int errors = 0;
  int seq_model = 0;
  int mq_seq [NIDS][$];
  int mq_beats [NIDS][$];
  int seen [NIDS];
  int exp_kind [$];
  int exp_id [$];
  int exp_seq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_order_chk #(.ID_W(ID_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .SEQ_W(SEQ_W)) u_rd_order_chk (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_id(ar_id), .ar_len(ar_len), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last),
    .done_valid(done_valid), .done_id(done_id), .done_seq(done_seq),
    .err_order(err_order), .err_length(err_length), .err_unknown(err_unknown)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: offer one read request for one edge
  task automatic do_ar(input int id, input int len);
    @(negedge clk);
    r_valid = 1'b0;
    ar_valid = 1'b1; ar_id = ID_W'(id); ar_len = LEN_W'(len);
    #1;
    if (ar_ready) begin
      mq_seq[id].push_back(seq_model % (1 << SEQ_W));
      mq_beats[id].push_back(len + 1);
      seq_model++;
    end
  endtask

  // driver: one handshaken beat, expected outcome pushed to the scoreboard
  task automatic do_beat(input int id, input bit last);
    @(negedge clk);
    ar_valid = 1'b0;
    r_valid = 1'b1; r_ready = 1'b1; r_id = ID_W'(id); r_last = last;
    if (mq_seq[id].size() == 0) begin
      exp_kind.push_back(K_UNK); exp_id.push_back(id); exp_seq.push_back(0);
    end else begin
      seen[id]++;
      if (last) begin
        int kind = K_OK;
        if (seen[id] != mq_beats[id][0]) begin
          kind = K_LEN;
          for (int k = 1; k < mq_beats[id].size(); k++)
            if (mq_beats[id][k] == seen[id]) kind = K_ORD;
        end
        exp_kind.push_back(kind); exp_id.push_back(id);
        exp_seq.push_back(mq_seq[id][0]);
        void'(mq_seq[id].pop_front());
        void'(mq_beats[id].pop_front());
        seen[id] = 0;
      end
    end
  endtask

  task automatic do_burst(input int id, input int beats);
    for (int b = 1; b <= beats; b++) do_beat(id, b == beats);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ar_valid = 1'b0; r_valid = 1'b0; r_ready = 1'b1;
    end
  endtask

  // monitor: pops the scoreboard whenever the design reports
  always @(negedge clk) begin
    if (rst_n && (done_valid || err_unknown)) begin
      int act_kind;
      act_kind = err_unknown ? K_UNK : err_order ? K_ORD : err_length ? K_LEN : K_OK;
      if (exp_kind.size() == 0) begin
        check("R3 spurious report", 1, 0);
      end else begin
        int ek, ei, es;
        ek = exp_kind.pop_front(); ei = exp_id.pop_front(); es = exp_seq.pop_front();
        case (ek)
          K_UNK: check("R4 unknown-ID flag", act_kind, ek);
          K_ORD: check("R7 order fault", act_kind, ek);
          K_LEN: check("R8 length fault", act_kind, ek);
          default: check("R6 clean completion", act_kind, ek);
        endcase
        if (ek != K_UNK) begin
          check("R3 done_id", int'(done_id), ei);
          check("R2 done_seq", int'(done_seq), es);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NIDS; i++) seen[i] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 ar_ready", int'(ar_ready), 1);
    check("R10 done_valid", int'(done_valid), 0);
    check("R10 faults", int'({err_order, err_length, err_unknown}), 0);
    rst_n = 1'b1;
    idle(1);

    // R9: beat without ready on an empty ID is ignored
    @(negedge clk);
    r_valid = 1'b1; r_ready = 1'b0; r_id = 3'd2; r_last = 1'b1;
    @(negedge clk);
    r_valid = 1'b0; r_ready = 1'b1;
    check("R9 no unknown flag", int'(err_unknown), 0);
    check("R9 no done", int'(done_valid), 0);

    // R4: beat for an ID with nothing outstanding
    do_beat(2, 1'b1);
    idle(2);

    // R5 R6: IDs 3,5,3,5 issued, both ID-5 bursts return first
    do_ar(3, 1); do_ar(5, 0); do_ar(3, 2); do_ar(5, 0);
    do_burst(5, 1); do_burst(5, 1); do_burst(3, 2); do_burst(3, 3);
    idle(2);

    // R1: fill ID 1, probe with ar_valid low
    do_ar(1, 0); do_ar(1, 0); do_ar(1, 0); do_ar(1, 0);
    @(negedge clk);
    ar_valid = 1'b0; ar_id = 3'd1; #1;
    check("R1 ready low on full ID", int'(ar_ready), 0);
    ar_id = 3'd6; #1;
    check("R1 ready high on other ID", int'(ar_ready), 1);
    do_burst(1, 1);
    idle(1);
    ar_id = 3'd1; #1;
    check("R1 ready back after retire", int'(ar_ready), 1);
    do_burst(1, 1); do_burst(1, 1); do_burst(1, 1);
    idle(2);

    // R7 then R8: younger 4-beat burst returned ahead of 1-beat head
    do_ar(4, 0); do_ar(4, 3);
    do_burst(4, 4);
    do_burst(4, 1);
    idle(2);

    // R8: short burst with no matching younger request
    do_ar(0, 2);
    do_burst(0, 2);
    // R6 with a wider ID mix and back-to-back issue
    do_ar(7, 5); do_ar(6, 0);
    do_burst(6, 1); do_burst(7, 6);
    idle(3);

    check("R3 all expected reports seen", exp_kind.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule